// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block turns a 32-bit CPU physical address into a device target. Software programs up to twenty windows through a small 32-bit register port. Each window has a control word that holds an enable, a sync-barrier request, a 4-bit target, an 8-bit attribute and a size mask. Each window also has a base word. The first group of windows can also replace the upper address bits of a hit with a remap value, so a window of CPU space can point at any equally sized, aligned region of the device.

A lookup presents an address together with a valid strobe. One cycle later the block returns whether any window claimed it, the winning window index, its target and attribute, and the translated address. When windows overlap, the lowest-numbered window wins and a multi-hit flag is raised. A write of a unit mask to the barrier register gives a one-cycle barrier request to the units it selects. A configuration write takes effect for lookups from the next cycle on.

Top module: `addr_window_decoder`

## Requirements
- R1: After synchronous reset, every register reads zero, no lookup result hits, and `barrier_req` is zero.
- R2: A control word keeps bit 0 (enable), bit 1 (sync request), bits 7:4 (target), bits 15:8 (attribute) and bits 31:16 (size minus one, in 64 KB granules), and reads bits 3:2 back as zero. Base and remap-low registers keep only bits 31:16 and read bits 15:0 back as zero.
- R3: Window w below 8 sits at byte offset w*16: control at +0x0, base at +0x4, remap-low at +0x8 and remap-high at +0xC (remap-high is a plain 32-bit register). Window w from 8 to 19 sits at 0x90 + (w-8)*8: control at +0x0 and base at +0x4.
- R4: Offsets that are not word aligned, offset 0x80, offset 0x88 to 0x8C, and offsets from 0xF0 up read zero, and writes to them change no register and no lookup.
- R5: A window hits when it is enabled and (addr[31:16] & ~size_mask) equals its base bits. A disabled window never hits, and clearing the control word removes the window.
- R6: When several windows hit, the lowest index is reported, with its target and attribute, and `res_multi` is 1. `res_multi` is 0 when one window or none hits.
- R7: For a hit on a window below 8, the translated address is {(remap[31:16] & ~mask) | (addr[31:16] & mask), addr[15:0]}.
- R8: A hit on a window from 8 up returns the address unchanged. A miss returns the address unchanged, with window, target and attribute all zero.
- R9: A result appears, with `res_valid` high, exactly one cycle after `lk_valid`. `res_valid` is low otherwise.
- R10: A write to offset 0x84 drives `cfg_wdata[15:0]` on `barrier_req` for exactly one cycle. Offset 0x84 reads zero.
- R11: `cfg_rdata` shows the register at `cfg_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| barrier_req | output | 16 | One-cycle barrier request per unit |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some window claimed the address |
| res_multi | output | 1 | More than one window claimed it |
| res_win | output | 5 | Winning window index |
| res_target | output | 4 | Target of the winning window |
| res_attr | output | 8 | Attribute of the winning window |
| res_addr | output | 32 | Translated address |

## Verification
Lookups are made just inside and just outside a window's size, which shows whether the size mask is applied correctly. They are also made on addresses claimed by two overlapping windows, which tests the priority order and the multi-hit flag. Back-to-back lookups, one to a remappable window and one to a window from 8 up, separate address translation from pass-through. Windows 7 and 8 test the edge of the remap range. A lookup to a window that was cleared or disabled confirms that it stops hitting. Writes to unmapped and unaligned offsets are followed by readback and by lookups, which shows that those writes reach no register.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int GRAN_W = 16;  // 64 KB granule
  localparam int PAGE_W = 16;  // upper address bits compared and remapped

  typedef enum logic [2:0] {
    RK_NONE, RK_CTRL, RK_BASE, RK_RMLO, RK_RMHI, RK_BARR
  } reg_kind_e;

  typedef struct packed {
    logic [PAGE_W-1:0] szm;
    logic [7:0]        attr;
    logic [3:0]        tgt;
    logic              sync;
    logic              en;
  } win_ctrl_t;

  function automatic logic [31:0] ctrl_to_word(win_ctrl_t c);
    return {c.szm, c.attr, c.tgt, 2'b00, c.sync, c.en};
  endfunction

  function automatic win_ctrl_t word_to_ctrl(logic [31:0] w);
    win_ctrl_t c;
    c.szm  = w[31:16];
    c.attr = w[15:8];
    c.tgt  = w[7:4];
    c.sync = w[1];
    c.en   = w[0];
    return c;
  endfunction
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN     = 20,
  parameter int NUM_REMAP   = 8,
  parameter int REG_AW      = 8,
  parameter int BARRIER_OFF = 'h84,
  parameter int HI_BASE     = 'h90,
  parameter int BAR_W       = 16,
  localparam int WIN_W      = $clog2(NUM_WIN),
  localparam int RM_W       = (NUM_REMAP > 1) ? $clog2(NUM_REMAP) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_wr,
  input  logic [REG_AW-1:0]                 cfg_addr,
  input  logic [31:0]                       cfg_wdata,
  output logic [31:0]                       cfg_rdata,
  output logic [BAR_W-1:0]                  barrier_req,
  output win_ctrl_t [NUM_WIN-1:0]           ctrl_o,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]    base_o,
  output logic [NUM_REMAP-1:0][PAGE_W-1:0]  remap_o
);
  localparam int LO_STRIDE = 16;
  localparam int HI_STRIDE = 8;
  localparam int LO_END    = NUM_REMAP * LO_STRIDE;
  localparam int HI_END    = HI_BASE + (NUM_WIN - NUM_REMAP) * HI_STRIDE;

  win_ctrl_t [NUM_WIN-1:0]          ctrl_q;
  logic [NUM_WIN-1:0][PAGE_W-1:0]   base_q;
  logic [NUM_REMAP-1:0][PAGE_W-1:0] rmlo_q;
  logic [NUM_REMAP-1:0][31:0]       rmhi_q;

  reg_kind_e        kind;
  logic [WIN_W-1:0] idx;
  logic [RM_W-1:0]  ridx;
  logic [31:0]      rd_next;

  // Irregular map: remappable windows with 16-byte stride, barrier in the gap,
  // then two-register windows with 8-byte stride.
  always_comb begin
    int o;
    int rel;
    kind = RK_NONE;
    idx  = '0;
    o    = int'(cfg_addr);
    rel  = o - HI_BASE;
    if (cfg_addr[1:0] == 2'b00) begin
      if (o < LO_END) begin
        idx = WIN_W'(o / LO_STRIDE);
        case ((o % LO_STRIDE) / 4)
          0:       kind = RK_CTRL;
          1:       kind = RK_BASE;
          2:       kind = RK_RMLO;
          default: kind = RK_RMHI;
        endcase
      end else if (o == BARRIER_OFF) begin
        kind = RK_BARR;
      end else if (o >= HI_BASE && o < HI_END) begin
        idx  = WIN_W'(NUM_REMAP + rel / HI_STRIDE);
        kind = ((rel % HI_STRIDE) == 0) ? RK_CTRL : RK_BASE;
      end
    end
  end

  assign ridx = idx[RM_W-1:0];

  always_comb begin
    case (kind)
      RK_CTRL: rd_next = ctrl_to_word(ctrl_q[idx]);
      RK_BASE: rd_next = {base_q[idx], {GRAN_W{1'b0}}};
      RK_RMLO: rd_next = {rmlo_q[ridx], {GRAN_W{1'b0}}};
      RK_RMHI: rd_next = rmhi_q[ridx];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      base_q      <= '0;
      rmlo_q      <= '0;
      rmhi_q      <= '0;
      cfg_rdata   <= '0;
      barrier_req <= '0;
    end else begin
      cfg_rdata   <= rd_next;
      barrier_req <= '0;
      if (cfg_wr) begin
        case (kind)
          RK_CTRL: ctrl_q[idx]  <= word_to_ctrl(cfg_wdata);
          RK_BASE: base_q[idx]  <= cfg_wdata[31:16];
          RK_RMLO: rmlo_q[ridx] <= cfg_wdata[31:16];
          RK_RMHI: rmhi_q[ridx] <= cfg_wdata;
          RK_BARR: barrier_req  <= cfg_wdata[BAR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign base_o  = base_q;
  assign remap_o = rmlo_q;

  p_barrier_one_shot_r10: assert property (@(posedge clk) disable iff (rst)
    (|barrier_req) |-> $past(cfg_wr && kind == RK_BARR));
  p_unmapped_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (kind == RK_NONE || kind == RK_BARR) |=> (cfg_rdata == 32'h0));
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8
) (
  input  logic [31:0]                       lk_addr,
  input  win_ctrl_t [NUM_WIN-1:0]           ctrl,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]    base,
  input  logic [NUM_REMAP-1:0][PAGE_W-1:0]  remap,
  output logic [NUM_WIN-1:0]                hit_vec,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]    xlat_hi
);
  logic [PAGE_W-1:0] page;
  assign page = lk_addr[31:GRAN_W];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [PAGE_W-1:0] msk;
    assign msk        = ctrl[i].szm;
    assign hit_vec[i] = ctrl[i].en && ((page & ~msk) == base[i]);
    if (i < NUM_REMAP) begin : g_remap
      assign xlat_hi[i] = (remap[i] & ~msk) | (page & msk);
    end else begin : g_pass
      assign xlat_hi[i] = page;
    end
  end
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 20,
  localparam int WIN_W  = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lk_valid,
  input  logic [31:0]                     lk_addr,
  input  logic [NUM_WIN-1:0]              hit_vec,
  input  logic [NUM_WIN-1:0][PAGE_W-1:0]  xlat_hi,
  input  win_ctrl_t [NUM_WIN-1:0]         ctrl,
  output logic                            res_valid,
  output logic                            res_hit,
  output logic                            res_multi,
  output logic [WIN_W-1:0]                res_win,
  output logic [3:0]                      res_target,
  output logic [7:0]                      res_attr,
  output logic [31:0]                     res_addr
);
  logic [WIN_W-1:0] sel;
  logic             any;

  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = WIN_W'(i);
    end
  end
  assign any = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_multi  <= 1'b0;
      res_win    <= '0;
      res_target <= '0;
      res_attr   <= '0;
      res_addr   <= '0;
    end else begin
      res_valid  <= lk_valid;
      res_hit    <= lk_valid && any;
      res_multi  <= lk_valid && ($countones(hit_vec) > 1);
      res_win    <= any ? sel : '0;
      res_target <= any ? ctrl[sel].tgt : 4'h0;
      res_attr   <= any ? ctrl[sel].attr : 8'h0;
      res_addr   <= any ? {xlat_hi[sel], lk_addr[GRAN_W-1:0]} : lk_addr;
    end
  end

  p_result_follows_request_r9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  p_no_spurious_result_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    res_multi |-> (res_hit && res_valid));
  p_low_half_kept_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_addr[GRAN_W-1:0] == $past(lk_addr[GRAN_W-1:0])));
  p_miss_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |->
      (res_addr == $past(lk_addr) && res_target == 4'h0 && res_attr == 8'h0));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN     = 20,
  parameter int NUM_REMAP   = 8,
  parameter int REG_AW      = 8,
  parameter int BARRIER_OFF = 'h84,
  parameter int HI_BASE     = 'h90,
  parameter int BAR_W       = 16,
  localparam int WIN_W      = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [BAR_W-1:0]  barrier_req,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_multi,
  output logic [WIN_W-1:0]  res_win,
  output logic [3:0]        res_target,
  output logic [7:0]        res_attr,
  output logic [31:0]       res_addr
);
  win_ctrl_t [NUM_WIN-1:0]          ctrl;
  logic [NUM_WIN-1:0][PAGE_W-1:0]   base;
  logic [NUM_REMAP-1:0][PAGE_W-1:0] remap;
  logic [NUM_WIN-1:0]               hit_vec;
  logic [NUM_WIN-1:0][PAGE_W-1:0]   xlat_hi;

  awd_regs #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW),
    .BARRIER_OFF(BARRIER_OFF), .HI_BASE(HI_BASE), .BAR_W(BAR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .barrier_req(barrier_req),
    .ctrl_o(ctrl), .base_o(base), .remap_o(remap)
  );

  awd_win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .lk_addr(lk_addr), .ctrl(ctrl), .base(base), .remap(remap),
    .hit_vec(hit_vec), .xlat_hi(xlat_hi)
  );

  awd_prio_sel #(.NUM_WIN(NUM_WIN)) u_sel (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .hit_vec(hit_vec), .xlat_hi(xlat_hi), .ctrl(ctrl),
    .res_valid(res_valid), .res_hit(res_hit), .res_multi(res_multi),
    .res_win(res_win), .res_target(res_target), .res_attr(res_attr),
    .res_addr(res_addr)
  );
endmodule

// File: tb/addr_window_decoder_test.sv
module addr_window_decoder_test;
  localparam int NW = 20;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] barrier_req;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_multi;
  logic [4:0]  res_win;
  logic [3:0]  res_target;
  logic [7:0]  res_attr;
  logic [31:0] res_addr;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .barrier_req(barrier_req),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_multi(res_multi), .res_win(res_win),
    .res_target(res_target), .res_attr(res_attr), .res_addr(res_addr)
  );

  // Software-visible model built from the requirements
  logic [31:0] m_ctrl [NW];
  logic [15:0] m_base [NW];
  logic [15:0] m_rm   [NR];

  typedef struct {
    logic [50:0] v;   // {hit, multi, win, tgt, attr, addr}
    string       tag;
  } exp_t;
  exp_t sb[$];

  function automatic int ctrl_off(int w);
    return (w < NR) ? w * 16 : 'h90 + (w - NR) * 8;
  endfunction

  function automatic exp_t predict(logic [31:0] a, string tag);
    exp_t e;
    int n = 0;
    logic hit = 0;
    logic [4:0] win = 0;
    logic [3:0] tgt = 0;
    logic [7:0] attr = 0;
    logic [31:0] o = a;
    for (int i = NW - 1; i >= 0; i--) begin
      logic [15:0] m;
      m = m_ctrl[i][31:16];
      if (m_ctrl[i][0] && ((a[31:16] & ~m) == m_base[i])) begin
        n++;
        hit = 1; win = 5'(i); tgt = m_ctrl[i][7:4]; attr = m_ctrl[i][15:8];
        o = a;
        if (i < NR) o = {(m_rm[i] & ~m) | (a[31:16] & m), a[15:0]};
      end
    end
    e.v = {hit, (n > 1) ? 1'b1 : 1'b0, win, tgt, attr, o};
    e.tag = tag;
    return e;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      nchk++;
      if (sb.size() == 0) begin
        nfail++;
        $display("FAIL R9: actual unexpected result expected none");
      end else begin
        exp_t e;
        logic [50:0] act;
        e = sb.pop_front();
        act = {res_hit, res_multi, res_win, res_target, res_attr, res_addr};
        if (act !== e.v) begin
          nfail++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
        end
      end
    end
  end

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(int off, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = 8'(off);
    @(negedge clk);
    check32(tag, cfg_rdata, exp);
  endtask

  task automatic set_win(int w, logic [31:0] c, logic [31:0] b, logic [31:0] r);
    wr(ctrl_off(w), c);
    wr(ctrl_off(w) + 4, b);
    m_ctrl[w] = c & 32'hFFFF_FFF3;
    m_base[w] = b[31:16];
    if (w < NR) begin
      wr(w * 16 + 8, r);
      m_rm[w] = r[31:16];
    end
  endtask

  task automatic lk(logic [31:0] a, string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    sb.push_back(predict(a, tag));
  endtask

  task automatic lk_end();
    @(negedge clk);
    lk_valid = 1'b0;
    repeat (2) @(negedge clk);
    nchk++;
    if (sb.size() != 0) begin
      nfail++;
      $display("FAIL R9: actual %0d pending expected 0", sb.size());
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_ctrl[i] = '0; m_base[i] = '0; end
    for (int i = 0; i < NR; i++) m_rm[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check32("R1 barrier", {16'h0, barrier_req}, 32'h0);
    check32("R1 res_valid", {31'h0, res_valid}, 32'h0);
    rd('h00, 32'h0, "R1 ctrl0");
    rd('hA4, 32'h0, "R1 base10");
    rd('h0C, 32'h0, "R1 rmhi0");
    lk(32'h4002_5678, "R1 miss"); lk_end();

    // R2/R3: window 0 layout, reserved bits and low bits dropped
    set_win(0, 32'h0003_A15F, 32'h4000_1234, 32'h8000_0000);
    rd('h00, 32'h0003_A153, "R2 ctrl0 readback");
    rd('h04, 32'h4000_0000, "R2 base0 readback");
    rd('h08, 32'h8000_0000, "R3 rmlo0 readback");
    wr('h0C, 32'h0000_0007);
    rd('h0C, 32'h0000_0007, "R3 rmhi0 readback");

    // R7 translate, R5 size edges
    lk(32'h4002_5678, "R7 remap win0");
    lk(32'h4003_FFFF, "R5 last byte in window");
    lk(32'h4004_0000, "R5 first byte past window");
    lk_end();

    // R8/R3: upper window 12 passes address through
    set_win(12, 32'h000F_3EC1, 32'h1000_0000, 32'h0);
    rd('hB0, 32'h000F_3EC1, "R3 ctrl12 at 0xB0");
    rd('hB4, 32'h1000_0000, "R3 base12 at 0xB4");
    // R6 overlap with window 3 (pass-through remap)
    set_win(3, 32'h0000_0721, 32'h100A_0000, 32'h100A_0000);
    lk(32'h100A_BCDE, "R6 overlap lowest wins");
    lk(32'h1001_0000, "R8 win12 passthrough");
    lk_end();

    // R5 disabled window stops hitting
    wr(ctrl_off(3), 32'h0000_0720); m_ctrl[3] = 32'h0000_0720;
    lk(32'h100A_0000, "R5 disabled win3");
    lk_end();

    // R7 vs R8 boundary: window 7 remaps, window 8 does not
    set_win(7, 32'h0000_0011, 32'h2000_0000, 32'h3000_0000);
    set_win(8, 32'h0001_0021, 32'h2100_0000, 32'h0);
    rd('h90, 32'h0001_0021, "R3 ctrl8 at 0x90");
    lk(32'h2000_0004, "R7 remap win7");
    lk(32'h2101_0008, "R8 no remap win8");
    lk_end();

    // R3 last window
    set_win(19, 32'h0000_1091, 32'hF000_0000, 32'h0);
    rd('hE8, 32'h0000_1091, "R3 ctrl19 at 0xE8");
    lk(32'hF000_0042, "R3 win19 lookup");
    lk_end();

    // R4 unmapped and unaligned offsets
    wr('h80, 32'hDEAD_BEEF);
    wr('h88, 32'hFFFF_FFFF);
    wr('hF0, 32'hFFFF_FFFF);
    wr('h02, 32'h0000_0000);
    wr('h91, 32'h0000_0000);
    rd('h80, 32'h0, "R4 read 0x80");
    rd('h88, 32'h0, "R4 read 0x88");
    rd('hF0, 32'h0, "R4 read 0xF0");
    rd('h00, 32'h0003_A153, "R4 ctrl0 intact");
    rd('h90, 32'h0001_0021, "R4 ctrl8 intact");
    lk(32'h4002_5678, "R4 win0 still decodes");
    lk_end();

    // R10 barrier pulse
    wr('h84, 32'h0000_FFFF);
    check32("R10 barrier pulse", {16'h0, barrier_req}, 32'h0000_FFFF);
    @(negedge clk);
    check32("R10 barrier clears", {16'h0, barrier_req}, 32'h0);
    wr('h84, 32'h1234_00A5);
    check32("R10 barrier mask", {16'h0, barrier_req}, 32'h0000_00A5);
    rd('h84, 32'h0, "R10 barrier reads zero");

    // R11 back-to-back reads return one cycle later
    @(negedge clk); cfg_addr = 8'h00;
    @(negedge clk); check32("R11 read ctrl0", cfg_rdata, 32'h0003_A153); cfg_addr = 8'hE8;
    @(negedge clk); check32("R11 read ctrl19", cfg_rdata, 32'h0000_1091);

    // R5 clear window 0 by writing zeros
    wr('h00, 32'h0); wr('h04, 32'h0);
    m_ctrl[0] = '0; m_base[0] = '0;
    lk(32'h4002_5678, "R5 cleared win0 misses");
    lk(32'h0000_1000, "R5 zero base not hit");
    lk_end();

    summary();
    $finish;
  end
endmodule